// File: doc/BRIEF.md
# Cache Way Allocation Mask Registers

This block holds one cache way mask for each class of service and turns it into a way-enable vector for every logical processor. Software programs the masks and the class selections through a single register port. Each access carries an address, a write flag, 64-bit write data and the index of the logical processor that issued it.

A mask must be one unbroken run of set bits that fits within the mask width. Any other value is refused: the stored mask keeps its old value and a fault flag is raised. Each logical processor owns an association register. The upper half of that register names the class the processor uses. A class number outside the supported range is refused in the same way.

The block also drives a fixed capability word that reports the mask length, the number of classes and the ways shared with other agents. The cache arrays and the replacement logic read `way_en_o` to decide which ways each processor may fill.

Top module: `cwa_alloc_top`

## Requirements
- R1: After reset every mask register holds all ones across the mask width (0x7FF for 11 ways). Every association register holds class 0, every way-enable slice is all ones, `fault_o` is 0 and `rd_data_o` is 0.
- R2: The mask for class n sits at address 0x0C90 + n. A read of that address returns the mask zero-extended to 64 bits on `rd_data_o` in the cycle after the request.
- R3: A mask write whose value is not one contiguous run of ones is refused and the stored mask is unchanged. A zero value counts as not contiguous. A mask of a single bit or of all bits is accepted.
- R4: A mask write with any bit set at or above the mask width (bit 11 and up by default) is refused and the stored mask is unchanged.
- R5: The association register at address 0x0C8F is private to the processor given on `req_lp_i`. Bits 63:32 of the write data select its class. A read returns the class in bits 63:32, with bits 31:0 reading 0.
- R6: An association write whose class value in bits 63:32 is at or above the number of classes (16 by default) is refused, and the old class is kept.
- R7: Slice `way_en_o[lp*WAY_W +: WAY_W]` equals the mask of the class that processor lp selects. It takes its new value one cycle after the association register or that mask register changes.
- R8: The capability outputs are fixed: mask width minus one (0x0A by default), number of classes minus one (0x000F by default), and the shared-way bit vector (0x600 by default).
- R9: `fault_o` is high for exactly the one cycle after a refused write. It stays 0 after accepted writes, after reads and when there is no request.
- R10: A write to an address outside the mask range and the association address changes no register and raises no fault. A read from such an address returns 0. Address 0x0CA0, one above the last class, is such an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 16 | Register address |
| req_lp_i | input | 2 | Logical processor issuing the access |
| req_wdata_i | input | 64 | Write data |
| rd_data_o | output | 64 | Read data, valid the cycle after a read request |
| fault_o | output | 1 | One-cycle pulse after a refused write |
| way_en_o | output | 44 | Way-enable vector, 11 bits per logical processor |
| cap_mask_len_o | output | 5 | Mask width minus one |
| cap_class_max_o | output | 16 | Number of classes minus one |
| cap_shared_o | output | 32 | Ways also used by other agents |

## Verification
Mask writes use several kinds of pattern: an upper run, a lower run, a single top bit, a single bottom bit and full width, which must all be accepted. They also use a gapped pattern, zero and a value with a bit above the width, which must all be refused. Reading back each mask tells a refused write apart from an update that was stored but not reported. The split of the upper seven ways against the lower four ways shows that two processors receive different masks. Changing only a mask that a processor already selects, and then only the selection, shows that either kind of change reaches `way_en_o` one cycle later. Class 15 against class 16 and address 0x0CA0 probe the edges of the valid class range and the mask address range.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  // True when m is a single non-empty run of ones
  function automatic logic is_run(input logic [63:0] m);
    logic [63:0] low;
    low = m & (~m + 64'd1);
    return (m != 64'd0) && (((m + low) & m) == 64'd0);
  endfunction
endpackage

// File: rtl/cwa_mask_check.sv
module cwa_mask_check #(
  parameter int WAY_W     = 11,
  parameter int NUM_CLASS = 16
) (
  input  logic [63:0] wdata_i,
  output logic        mask_ok_o,
  output logic        class_ok_o
);
  logic [63:0] above;
  assign above      = wdata_i >> WAY_W;
  assign mask_ok_o  = cwa_pkg::is_run(wdata_i) && (above == 64'd0);
  assign class_ok_o = wdata_i[63:32] < 32'(NUM_CLASS);
endmodule

// File: rtl/cwa_mask_bank.sv
module cwa_mask_bank #(
  parameter int NUM_CLASS = 16,
  parameter int WAY_W     = 11,
  parameter int CLS_W     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [CLS_W-1:0]           idx_i,
  input  logic [WAY_W-1:0]           wmask_i,
  output logic [NUM_CLASS*WAY_W-1:0] masks_o
);
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    logic [WAY_W-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mask_q <= '1;
      else if (we_i && idx_i == CLS_W'(c))       mask_q <= wmask_i;
    end
    assign masks_o[c*WAY_W +: WAY_W] = mask_q;
  end
endmodule

// File: rtl/cwa_assoc_bank.sv
module cwa_assoc_bank #(
  parameter int NUM_LP = 4,
  parameter int CLS_W  = 4,
  parameter int LP_W   = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [LP_W-1:0]         lp_i,
  input  logic [CLS_W-1:0]        cls_i,
  output logic [NUM_LP*CLS_W-1:0] cls_o
);
  for (genvar l = 0; l < NUM_LP; l++) begin : g_lp
    logic [CLS_W-1:0] cls_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cls_q <= '0;
      else if (we_i && lp_i == LP_W'(l))    cls_q <= cls_i;
    end
    assign cls_o[l*CLS_W +: CLS_W] = cls_q;
  end
endmodule

// File: rtl/cwa_way_sel.sv
module cwa_way_sel #(
  parameter int NUM_LP    = 4,
  parameter int NUM_CLASS = 16,
  parameter int WAY_W     = 11,
  parameter int CLS_W     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CLASS*WAY_W-1:0] masks_i,
  input  logic [NUM_LP*CLS_W-1:0]    cls_i,
  output logic [NUM_LP*WAY_W-1:0]    way_en_o
);
  for (genvar l = 0; l < NUM_LP; l++) begin : g_lp
    logic [CLS_W-1:0] sel;
    logic [WAY_W-1:0] en_q;
    assign sel = cls_i[l*CLS_W +: CLS_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= '1;
      else         en_q <= masks_i[sel*WAY_W +: WAY_W];
    end
    assign way_en_o[l*WAY_W +: WAY_W] = en_q;
  end
endmodule

// File: rtl/cwa_alloc_top.sv
module cwa_alloc_top #(
  parameter int          NUM_LP      = 4,
  parameter int          NUM_CLASS   = 16,
  parameter int          WAY_W       = 11,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] MASK_BASE   = 16'h0C90,
  parameter logic [15:0] ASSOC_ADDR  = 16'h0C8F,
  parameter logic [31:0] SHARED_WAYS = 32'h0000_0600,
  localparam int CLS_W = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1,
  localparam int LP_W  = (NUM_LP > 1) ? $clog2(NUM_LP) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_write_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [LP_W-1:0]         req_lp_i,
  input  logic [63:0]             req_wdata_i,
  output logic [63:0]             rd_data_o,
  output logic                    fault_o,
  output logic [NUM_LP*WAY_W-1:0] way_en_o,
  output logic [4:0]              cap_mask_len_o,
  output logic [15:0]             cap_class_max_o,
  output logic [31:0]             cap_shared_o
);
  logic [NUM_CLASS*WAY_W-1:0] masks;
  logic [NUM_LP*CLS_W-1:0]    cls;
  logic [ADDR_W-1:0]          off;
  logic [CLS_W-1:0]           idx;
  logic                       hit_mask, hit_assoc, lp_ok;
  logic                       mask_ok, class_ok;
  logic                       mask_we, assoc_we, bad_wr;
  logic [63:0]                rd_d, rd_q;
  logic                       fault_q;

  assign off       = req_addr_i - ADDR_W'(MASK_BASE);
  assign hit_mask  = off < ADDR_W'(NUM_CLASS);
  assign idx       = off[CLS_W-1:0];
  assign hit_assoc = req_addr_i == ADDR_W'(ASSOC_ADDR);
  assign lp_ok     = 32'(req_lp_i) < 32'(NUM_LP);

  cwa_mask_check #(.WAY_W(WAY_W), .NUM_CLASS(NUM_CLASS)) u_check (
    .wdata_i   (req_wdata_i),
    .mask_ok_o (mask_ok),
    .class_ok_o(class_ok)
  );

  assign mask_we  = req_valid_i && req_write_i && hit_mask && mask_ok;
  assign assoc_we = req_valid_i && req_write_i && hit_assoc && class_ok && lp_ok;
  assign bad_wr   = req_valid_i && req_write_i &&
                    ((hit_mask && !mask_ok) || (hit_assoc && (!class_ok || !lp_ok)));

  cwa_mask_bank #(.NUM_CLASS(NUM_CLASS), .WAY_W(WAY_W), .CLS_W(CLS_W)) u_masks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .idx_i  (idx),
    .wmask_i(req_wdata_i[WAY_W-1:0]),
    .masks_o(masks)
  );

  cwa_assoc_bank #(.NUM_LP(NUM_LP), .CLS_W(CLS_W), .LP_W(LP_W)) u_assoc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (assoc_we),
    .lp_i  (req_lp_i),
    .cls_i (req_wdata_i[32 +: CLS_W]),
    .cls_o (cls)
  );

  cwa_way_sel #(.NUM_LP(NUM_LP), .NUM_CLASS(NUM_CLASS), .WAY_W(WAY_W), .CLS_W(CLS_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .masks_i (masks),
    .cls_i   (cls),
    .way_en_o(way_en_o)
  );

  always_comb begin
    rd_d = '0;
    if (hit_mask) begin
      rd_d[WAY_W-1:0] = masks[idx*WAY_W +: WAY_W];
    end else if (hit_assoc && lp_ok) begin
      rd_d[32 +: CLS_W] = cls[req_lp_i*CLS_W +: CLS_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= bad_wr;
      if (req_valid_i && !req_write_i) rd_q <= rd_d;
    end
  end

  assign rd_data_o       = rd_q;
  assign fault_o         = fault_q;
  assign cap_mask_len_o  = 5'(WAY_W - 1);
  assign cap_class_max_o = 16'(NUM_CLASS - 1);
  assign cap_shared_o    = SHARED_WAYS;
endmodule

// File: rtl/cwa_alloc_sva.sv
module cwa_alloc_sva #(
  parameter int NUM_LP    = 4,
  parameter int NUM_CLASS = 16,
  parameter int WAY_W     = 11,
  parameter int CLS_W     = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_valid_i,
  input logic                       req_write_i,
  input logic                       fault_o,
  input logic [NUM_CLASS*WAY_W-1:0] masks,
  input logic [NUM_LP*CLS_W-1:0]    cls,
  input logic [NUM_LP*WAY_W-1:0]    way_en_o
);
  // R9
  a_r9_fault_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(req_valid_i && req_write_i));
  // R3, R4
  a_r3_fault_keeps_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> masks == $past(masks));
  // R6
  a_r6_fault_keeps_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> cls == $past(cls));

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_c
    a_r3_masks_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cwa_pkg::is_run(64'(masks[c*WAY_W +: WAY_W])));
  end
  for (genvar l = 0; l < NUM_LP; l++) begin : g_l
    a_r6_class_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(cls[l*CLS_W +: CLS_W]) < 32'(NUM_CLASS));
    a_r7_way_en_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cwa_pkg::is_run(64'(way_en_o[l*WAY_W +: WAY_W])));
  end
endmodule

bind cwa_alloc_top cwa_alloc_sva #(
  .NUM_LP(NUM_LP), .NUM_CLASS(NUM_CLASS), .WAY_W(WAY_W), .CLS_W(CLS_W)
) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .fault_o    (fault_o),
  .masks      (masks),
  .cls        (cls),
  .way_en_o   (way_en_o)
);

// File: tb/cwa_alloc_top_tb_top.sv
module cwa_alloc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_lp = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_data;
  logic        fault;
  logic [43:0] way_en;
  logic [4:0]  cap_len;
  logic [15:0] cap_cls;
  logic [31:0] cap_sh;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  cwa_alloc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_lp_i(req_lp), .req_wdata_i(req_wdata),
    .rd_data_o(rd_data), .fault_o(fault), .way_en_o(way_en),
    .cap_mask_len_o(cap_len), .cap_class_max_o(cap_cls), .cap_shared_o(cap_sh)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // returns fault_o sampled one cycle after the write edge
  task automatic wr(input logic [15:0] a, input logic [1:0] lp, input logic [63:0] d,
                    output logic f);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_lp = lp; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    f = fault;
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] lp, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_lp = lp;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [10:0] lane(input int lp);
    return way_en[lp*11 +: 11];
  endfunction

  task automatic t_reset();
    logic [63:0] d;
    check("R1 fault", 64'(fault), 64'd0);
    check("R1 rd_data", rd_data, 64'd0);
    for (int l = 0; l < 4; l++) check("R1 way_en", 64'(lane(l)), 64'h7FF);
    rd(16'h0C9F, 2'd0, d); check("R1 mask15", d, 64'h7FF);
    rd(16'h0C8F, 2'd3, d); check("R1 assoc", d, 64'd0);
    check("R8 len", 64'(cap_len), 64'h0A);
    check("R8 classes", 64'(cap_cls), 64'h0F);
    check("R8 shared", 64'(cap_sh), 64'h600);
  endtask

  task automatic t_split();
    logic f; logic [63:0] d;
    wr(16'h0C90, 2'd0, 64'h7F0, f); check("R9 ok write", 64'(f), 64'd0);
    wr(16'h0C91, 2'd0, 64'h00F, f); check("R9 ok write", 64'(f), 64'd0);
    rd(16'h0C90, 2'd0, d); check("R2 class0", d, 64'h7F0);
    rd(16'h0C91, 2'd0, d); check("R2 class1", d, 64'h00F);
    wr(16'h0C8F, 2'd1, 64'h1_0000_0000, f); check("R5 assoc ok", 64'(f), 64'd0);
    @(negedge clk);
    check("R7 lp1 class1", 64'(lane(1)), 64'h00F);
    check("R7 lp0 class0", 64'(lane(0)), 64'h7F0);
    check("R7 lp2 class0", 64'(lane(2)), 64'h7F0);
    rd(16'h0C8F, 2'd1, d); check("R5 assoc read", d, 64'h1_0000_0000);
    rd(16'h0C8F, 2'd0, d); check("R5 assoc private", d, 64'd0);
  endtask

  task automatic t_latency();
    logic f;
    // change only the selected mask
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0C91; req_wdata = 64'h03C;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R7 not yet", 64'(lane(1)), 64'h00F);
    @(negedge clk);
    check("R7 mask change", 64'(lane(1)), 64'h03C);
    // change only the selection
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0C8F; req_lp = 2'd1; req_wdata = 64'd0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R7 not yet", 64'(lane(1)), 64'h03C);
    @(negedge clk);
    check("R7 assoc change", 64'(lane(1)), 64'h7F0);
    wr(16'h0C8F, 2'd1, 64'h1_0000_0000, f);
  endtask

  task automatic t_reject();
    logic f; logic [63:0] d;
    wr(16'h0C91, 2'd0, 64'h505, f); check("R3 gap fault", 64'(f), 64'd1);
    @(negedge clk); check("R9 pulse ends", 64'(fault), 64'd0);
    rd(16'h0C91, 2'd0, d); check("R3 gap kept", d, 64'h03C);
    wr(16'h0C91, 2'd0, 64'h000, f); check("R3 zero fault", 64'(f), 64'd1);
    rd(16'h0C91, 2'd0, d); check("R3 zero kept", d, 64'h03C);
    wr(16'h0C91, 2'd0, 64'h800, f); check("R4 wide fault", 64'(f), 64'd1);
    wr(16'h0C91, 2'd0, 64'hFFF, f); check("R4 wide run fault", 64'(f), 64'd1);
    rd(16'h0C91, 2'd0, d); check("R4 kept", d, 64'h03C);
    check("R3 lane kept", 64'(lane(1)), 64'h03C);
    wr(16'h0C92, 2'd0, 64'h400, f); check("R3 top bit ok", 64'(f), 64'd0);
    wr(16'h0C93, 2'd0, 64'h001, f); check("R3 bottom bit ok", 64'(f), 64'd0);
    wr(16'h0C9F, 2'd0, 64'h7FF, f); check("R3 full ok", 64'(f), 64'd0);
    rd(16'h0C92, 2'd0, d); check("R3 top bit stored", d, 64'h400);
    rd(16'h0C93, 2'd0, d); check("R3 bottom bit stored", d, 64'h001);
  endtask

  task automatic t_class_range();
    logic f; logic [63:0] d;
    wr(16'h0C8F, 2'd2, 64'h10_0000_0000, f); check("R6 class16 fault", 64'(f), 64'd1);
    rd(16'h0C8F, 2'd2, d); check("R6 class kept", d, 64'd0);
    wr(16'h0C8F, 2'd2, 64'h0F_0000_0000, f); check("R6 class15 ok", 64'(f), 64'd0);
    rd(16'h0C8F, 2'd2, d); check("R6 class15 stored", d, 64'hF_0000_0000);
    @(negedge clk); check("R7 lp2 class15", 64'(lane(2)), 64'h7FF);
    wr(16'h0C8F, 2'd3, 64'h02_0000_0000, f);
    @(negedge clk); check("R7 lp3 class2", 64'(lane(3)), 64'h400);
  endtask

  task automatic t_unmapped();
    logic f; logic [63:0] d;
    wr(16'h0CA0, 2'd0, 64'h00F, f); check("R10 no fault", 64'(f), 64'd0);
    rd(16'h0CA0, 2'd0, d); check("R10 reads zero", d, 64'd0);
    rd(16'h0C9F, 2'd0, d); check("R10 last class kept", d, 64'h7FF);
    wr(16'h0C8E, 2'd0, 64'h505, f); check("R10 below no fault", 64'(f), 64'd0);
    check("R10 lanes kept", 64'(lane(0)), 64'h7F0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split();
    t_latency();
    t_reject();
    t_class_range();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule